// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide register front end of one priority interrupt controller instance. A one-bit address selects a command port (0) and a data port (1). Writes on these ports run a four-step configuration sequence, load the mask, issue end-of-interrupt and priority-rotation commands, choose which register a status read returns, and arm a one-shot poll. The block owns the in-service register, the mask register, the rotating priority base and the mode flags, and drives them out to the resolver datapath.

The resolver is outside this block. It supplies the live request register, the index of the currently winning request, and an in-service set mask from its acknowledge path. It receives a one-cycle initialization pulse that tells it to clear its own request and edge state and to drop the interrupt output. A poll read also produces a one-hot request-clear strobe for the winning line. Write effects land on the clock edge that samples the write strobe. Read data is combinational. Poll side effects land on the edge that samples the read strobe.

Top module: `pic_prog_if`

## Requirements
- R1: After reset, the in-service register, mask, vector base, priority base, auto-EOI, rotate-on-auto-EOI, fully-nested and special-mask outputs are all zero, no poll is armed, status reads return the request register, and a read at address 1 returns 0.
- R2: A write to address 0 with data bit 4 set clears the in-service register, mask, vector base, priority base, read select, poll and all mode flags. On the next cycle it raises `init_pulse_o` for exactly one cycle. It captures "fourth word needed" from bit 0 and "single" from bit 1, and the next address-1 write is then taken as the vector-base word.
- R3: The vector-base word loads `vec_base_o` from data[7:3]. The sequencer goes next to a cascade word if "single" is clear, otherwise to a mode word if a fourth word is needed, otherwise back to normal. A cascade word changes no output, and it is followed by a mode word only if a fourth word is needed. A mode word sets `fully_nested_o` from bit 4 and `auto_eoi_o` from bit 1, and returns to normal.
- R4: In normal state an address-1 write loads the mask. With no poll armed, an address-1 read returns the mask.
- R5: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 arms a poll. When bit 1 is set, bit 0 picks what status reads return: 1 for the in-service register, 0 for the request register. When bit 6 is set, bit 5 becomes the special-mask flag. A cleared bit 1 or bit 6 leaves the matching setting unchanged.
- R6: A command word (address 0, bits 4 and 3 clear, code in bits 7:5) with code 1 clears the highest-priority in-service bit. Priority is highest at the line equal to the priority base and falls with ascending line number, modulo 8. Code 5 does the same and then sets the priority base to that line + 1. When no in-service bit is set, neither code changes anything.
- R7: Code 3 clears in-service bit data[2:0]. Code 7 also sets the priority base to data[2:0] + 1. Code 6 only sets the priority base to data[2:0] + 1. All of these wrap modulo 8.
- R8: Codes 0 and 4 set `rot_aeoi_o` to data bit 7. Code 2 changes no state.
- R9: While a poll is armed, a read at either address returns {5'b0, pending index} if a request is pending and 8'h07 otherwise, and the poll is disarmed. If a request is pending, then during that read strobe `irr_clr_o` is one-hot at the pending line, and the line's in-service bit is cleared. Otherwise `irr_clr_o` stays zero.
- R10: Bits of `isr_set_i` are set in the in-service register on the next edge. A clear of the same bit in the same cycle acts on the old value, so the set wins. An initialization write overrides both.
- R11: With no poll armed, an address-0 read returns `irr_i` when the request register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 1 | Port select: 0 command, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| irr_i | input | 8 | Request register from the resolver |
| pend_vld_i | input | 1 | Resolver has a winning request |
| pend_idx_i | input | 3 | Line of the winning request |
| isr_set_i | input | 8 | In-service set mask from the acknowledge path |
| init_pulse_o | output | 1 | One-cycle pulse after an initialization write |
| irr_clr_o | output | 8 | One-hot request clear during a poll read |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| vec_base_o | output | 5 | Vector base, upper five bits |
| prio_base_o | output | 3 | Line that currently holds top priority |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| fully_nested_o | output | 1 | Special fully-nested mode |
| spec_mask_o | output | 1 | Special mask mode |

## Verification
The bench builds the block with its default parameters of eight lines and byte-wide data. That size is the only one the command bit fields decode, so every command code, every wrap of the priority base from line 7 to line 0, and all three skip paths of the configuration sequence can be reached. The vector table steps through rotation-dependent end-of-interrupt scans whose expected line moves with the priority base. The directed tests cover the cascade-only, fourth-word-only and single paths, a poll with and without a pending request, and a set and a clear of the same in-service bit in one cycle.

// File: rtl/pic_if_pkg.sv
package pic_if_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned LINE_W    = $clog2(NUM_LINES);
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned VBASE_W   = DATA_W - LINE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_VEC  = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_st_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_ON  = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_e;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // scan from lowest priority up so the last hit is the highest
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int p;
      p = (i + int'(base_i)) % N;
      if (vec_i[p]) begin
        vld_o = 1'b1;
        idx_o = IW'(p);
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_if_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    single_i,
  input  logic    need4_i,
  input  logic    data_wr_i,
  output seq_st_e state_o
);
  seq_st_e st_q;
  logic    single_q, need4_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (start_i) begin
      st_q     <= SEQ_VEC;
      single_q <= single_i;
      need4_q  <= need4_i;
    end else if (data_wr_i) begin
      unique case (st_q)
        SEQ_VEC:  st_q <= !single_q ? SEQ_CASC : (need4_q ? SEQ_MODE : SEQ_IDLE);
        SEQ_CASC: st_q <= need4_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/pic_cmd_exec.sv
module pic_cmd_exec
  import pic_if_pkg::*;
(
  input  logic                 cmd_vld_i,
  input  op_e                  op_i,
  input  logic [LINE_W-1:0]    lvl_i,
  input  logic [NUM_LINES-1:0] isr_i,
  input  logic [LINE_W-1:0]    base_i,
  output logic [NUM_LINES-1:0] clr_o,
  output logic                 base_we_o,
  output logic [LINE_W-1:0]    base_o,
  output logic                 rot_we_o
);
  logic              top_vld;
  logic [LINE_W-1:0] top_idx;

  pic_prio_pick #(.N(NUM_LINES), .IW(LINE_W)) u_pick (
    .vec_i (isr_i),
    .base_i(base_i),
    .vld_o (top_vld),
    .idx_o (top_idx)
  );

  always_comb begin
    clr_o     = '0;
    base_we_o = 1'b0;
    base_o    = base_i;
    rot_we_o  = 1'b0;
    if (cmd_vld_i) begin
      unique case (op_i)
        OP_ROT_OFF, OP_ROT_ON: rot_we_o = 1'b1;
        OP_EOI, OP_REOI: begin
          if (top_vld) begin
            clr_o[top_idx] = 1'b1;
            if (op_i == OP_REOI) begin
              base_we_o = 1'b1;
              base_o    = top_idx + LINE_W'(1);
            end
          end
        end
        OP_SEOI: clr_o[lvl_i] = 1'b1;
        OP_SETPRI: begin
          base_we_o = 1'b1;
          base_o    = lvl_i + LINE_W'(1);
        end
        OP_RSEOI: begin
          clr_o[lvl_i] = 1'b1;
          base_we_o    = 1'b1;
          base_o       = lvl_i + LINE_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
  import pic_if_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic                 addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic                 pend_vld_i,
  input  logic [LINE_W-1:0]    pend_idx_i,
  input  logic [NUM_LINES-1:0] isr_set_i,
  output logic                 init_pulse_o,
  output logic [NUM_LINES-1:0] irr_clr_o,
  output logic [NUM_LINES-1:0] isr_o,
  output logic [NUM_LINES-1:0] imr_o,
  output logic [VBASE_W-1:0]   vec_base_o,
  output logic [LINE_W-1:0]    prio_base_o,
  output logic                 auto_eoi_o,
  output logic                 rot_aeoi_o,
  output logic                 fully_nested_o,
  output logic                 spec_mask_o
);
  seq_st_e seq_st;

  logic cmd_wr, start_wr, ctl_wr, op_wr, data_wr;
  assign cmd_wr   = wr_i && !addr_i;
  assign data_wr  = wr_i && addr_i;
  assign start_wr = cmd_wr && wdata_i[4];
  assign ctl_wr   = cmd_wr && !wdata_i[4] && wdata_i[3];
  assign op_wr    = cmd_wr && !wdata_i[4] && !wdata_i[3];

  pic_init_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_wr),
    .single_i (wdata_i[1]),
    .need4_i  (wdata_i[0]),
    .data_wr_i(data_wr),
    .state_o  (seq_st)
  );

  logic [NUM_LINES-1:0] isr_q, imr_q;
  logic [VBASE_W-1:0]   vbase_q;
  logic [LINE_W-1:0]    pbase_q;
  logic aeoi_q, rot_q, fnest_q, smask_q, sel_isr_q, poll_q, init_q;

  logic [NUM_LINES-1:0] cmd_clr;
  logic                 base_we, rot_we;
  logic [LINE_W-1:0]    base_nxt;

  pic_cmd_exec u_exec (
    .cmd_vld_i(op_wr),
    .op_i     (op_e'(wdata_i[7:5])),
    .lvl_i    (wdata_i[LINE_W-1:0]),
    .isr_i    (isr_q),
    .base_i   (pbase_q),
    .clr_o    (cmd_clr),
    .base_we_o(base_we),
    .base_o   (base_nxt),
    .rot_we_o (rot_we)
  );

  logic poll_rd, poll_hit;
  assign poll_rd   = rd_i && poll_q;
  assign poll_hit  = poll_rd && pend_vld_i;
  assign irr_clr_o = poll_hit ? (NUM_LINES'(1) << pend_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q     <= '0;
      imr_q     <= '0;
      vbase_q   <= '0;
      pbase_q   <= '0;
      aeoi_q    <= 1'b0;
      rot_q     <= 1'b0;
      fnest_q   <= 1'b0;
      smask_q   <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
      init_q    <= 1'b0;
    end else begin
      init_q <= start_wr;
      if (start_wr) begin
        isr_q     <= '0;
        imr_q     <= '0;
        vbase_q   <= '0;
        pbase_q   <= '0;
        aeoi_q    <= 1'b0;
        rot_q     <= 1'b0;
        fnest_q   <= 1'b0;
        smask_q   <= 1'b0;
        sel_isr_q <= 1'b0;
        poll_q    <= 1'b0;
      end else begin
        // clears act on the old value, sets land on top
        isr_q <= (isr_q & ~(cmd_clr | irr_clr_o)) | isr_set_i;
        if (base_we) pbase_q <= base_nxt;
        if (rot_we)  rot_q   <= wdata_i[7];
        if (poll_rd) poll_q  <= 1'b0;
        if (ctl_wr) begin
          if (wdata_i[2]) poll_q    <= 1'b1;
          if (wdata_i[1]) sel_isr_q <= wdata_i[0];
          if (wdata_i[6]) smask_q   <= wdata_i[5];
        end
        if (data_wr) begin
          unique case (seq_st)
            SEQ_IDLE: imr_q   <= wdata_i;
            SEQ_VEC:  vbase_q <= wdata_i[DATA_W-1:LINE_W];
            SEQ_MODE: begin
              fnest_q <= wdata_i[4];
              aeoi_q  <= wdata_i[1];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (poll_q)
      rdata_o = pend_vld_i ? DATA_W'(pend_idx_i) : DATA_W'(7);
    else if (addr_i)
      rdata_o = imr_q;
    else
      rdata_o = sel_isr_q ? isr_q : irr_i;
  end

  assign init_pulse_o   = init_q;
  assign isr_o          = isr_q;
  assign imr_o          = imr_q;
  assign vec_base_o     = vbase_q;
  assign prio_base_o    = pbase_q;
  assign auto_eoi_o     = aeoi_q;
  assign rot_aeoi_o     = rot_q;
  assign fully_nested_o = fnest_q;
  assign spec_mask_o    = smask_q;
endmodule

// File: rtl/pic_prog_if_chk.sv
module pic_prog_if_chk
  import pic_if_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic                 addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_LINES-1:0] irr_i,
  input logic                 pend_vld_i,
  input logic [LINE_W-1:0]    pend_idx_i,
  input logic [NUM_LINES-1:0] isr_set_i,
  input logic                 init_pulse_o,
  input logic [NUM_LINES-1:0] irr_clr_o,
  input logic [NUM_LINES-1:0] isr_o,
  input logic [NUM_LINES-1:0] imr_o,
  input logic [VBASE_W-1:0]   vec_base_o,
  input logic [LINE_W-1:0]    prio_base_o,
  input logic                 auto_eoi_o,
  input logic                 rot_aeoi_o,
  input logic                 fully_nested_o,
  input logic                 spec_mask_o
);
  // R2
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=>
      (init_pulse_o && imr_o == '0 && vec_base_o == '0 && prio_base_o == '0 &&
       !auto_eoi_o && !rot_aeoi_o && !fully_nested_o && !spec_mask_o));

  // R2
  init_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_o |=> !init_pulse_o || $past(wr_i && !addr_i && wdata_i[4]));

  // R9
  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irr_clr_o));

  // R9
  clr_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_clr_o != '0) |-> (rd_i && pend_vld_i && irr_clr_o[pend_idx_i]));

  // R10
  isr_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_set_i != '0 && !(wr_i && !addr_i && wdata_i[4])) |=>
      ((isr_o & $past(isr_set_i)) == $past(isr_set_i)));

  // R6
  eoi_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b00100 && isr_set_i == '0 && !rd_i) |=>
      ($countones(isr_o) + (($past(isr_o) != '0) ? 1 : 0) == $countones($past(isr_o))));

  // R8
  nop_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b01000 && isr_set_i == '0 && !rd_i) |=>
      ($stable(isr_o) && $stable(prio_base_o) && $stable(rot_aeoi_o)));
endmodule

bind pic_prog_if pic_prog_if_chk u_chk (.*);

// File: tb/tb_pic_prog_if.sv
module tb_pic_prog_if;
  import pic_if_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr_set = '0;
  logic       pend_vld = 1'b0;
  logic [2:0] pend_idx = '0;
  logic [7:0] rdata, irr_clr, isr, imr;
  logic [4:0] vec_base;
  logic [2:0] prio_base;
  logic       init_pulse, aeoi, rot, fnest, smask;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  pic_prog_if dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .pend_vld_i(pend_vld),
    .pend_idx_i(pend_idx), .isr_set_i(isr_set), .init_pulse_o(init_pulse),
    .irr_clr_o(irr_clr), .isr_o(isr), .imr_o(imr), .vec_base_o(vec_base),
    .prio_base_o(prio_base), .auto_eoi_o(aeoi), .rot_aeoi_o(rot),
    .fully_nested_o(fnest), .spec_mask_o(smask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_set(input logic [7:0] m);
    @(negedge clk);
    isr_set = m;
    @(negedge clk);
    isr_set = '0;
  endtask

  task automatic do_rd(input string req, input logic a, input logic [7:0] exp);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 chk(req, rdata, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  // entry: op(0 write,1 read-check,2 isr set), addr, data, expected, requirement number
  localparam int NV = 35;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0,1'b0,8'h13,8'h00,4'd2},  // R2 init: single, fourth word
    {2'd0,1'b1,8'h48,8'h00,4'd3},  // R3 vector word
    {2'd0,1'b1,8'h02,8'h00,4'd3},  // R3 mode word
    {2'd0,1'b1,8'hA5,8'h00,4'd4},  // R4 mask
    {2'd1,1'b1,8'h00,8'hA5,4'd4},
    {2'd1,1'b0,8'h00,8'h5A,4'd11}, // R11 request read
    {2'd2,1'b0,8'h90,8'h00,4'd10},
    {2'd0,1'b0,8'h0B,8'h00,4'd5},  // R5 select in-service
    {2'd1,1'b0,8'h00,8'h90,4'd5},
    {2'd0,1'b0,8'h20,8'h00,4'd6},  // R6 clears line 4
    {2'd1,1'b0,8'h00,8'h80,4'd6},
    {2'd0,1'b0,8'hA0,8'h00,4'd6},  // R6 rotating: line 7, base wraps to 0
    {2'd1,1'b0,8'h00,8'h00,4'd6},
    {2'd2,1'b0,8'h11,8'h00,4'd10},
    {2'd0,1'b0,8'hC4,8'h00,4'd7},  // R7 base = 5
    {2'd0,1'b0,8'h20,8'h00,4'd6},  // R6 scan from 5 hits line 0
    {2'd1,1'b0,8'h00,8'h10,4'd6},
    {2'd0,1'b0,8'h64,8'h00,4'd7},  // R7 specific clear 4
    {2'd1,1'b0,8'h00,8'h00,4'd7},
    {2'd2,1'b0,8'h06,8'h00,4'd10},
    {2'd0,1'b0,8'hE1,8'h00,4'd7},  // R7 clear 1, base = 2
    {2'd1,1'b0,8'h00,8'h04,4'd7},
    {2'd0,1'b0,8'h20,8'h00,4'd6},
    {2'd1,1'b0,8'h00,8'h00,4'd6},
    {2'd2,1'b0,8'h08,8'h00,4'd10},
    {2'd0,1'b0,8'h40,8'h00,4'd8},  // R8 code 2
    {2'd1,1'b0,8'h00,8'h08,4'd8},
    {2'd0,1'b0,8'h63,8'h00,4'd7},
    {2'd1,1'b0,8'h00,8'h00,4'd7},
    {2'd0,1'b0,8'h0C,8'h00,4'd9},  // R9 arm poll
    {2'd1,1'b1,8'h00,8'h03,4'd9},
    {2'd1,1'b1,8'h00,8'hA5,4'd4},  // R4 poll disarmed
    {2'd0,1'b0,8'h0A,8'h00,4'd5},  // R5 select request
    {2'd1,1'b0,8'h00,8'h5A,4'd11},
    {2'd0,1'b0,8'h28,8'h00,4'd5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    addr = 1'b1;
    #1;
    // R1 reset state
    chk("R1 isr", isr, 0);
    chk("R1 imr", imr, 0);
    chk("R1 modes", {vec_base, prio_base, aeoi, rot, fnest, smask, init_pulse}, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    addr = 1'b0;
    #1 chk("R1 status reads request", rdata, 0);

    irr = 8'h5A; pend_vld = 1'b1; pend_idx = 3'd3;
    for (int k = 0; k < NV; k++) begin
      logic [22:0] e;
      e = VEC[k];
      case (e[22:21])
        2'd0: do_wr(e[20], e[19:12]);
        2'd1: do_rd($sformatf("table %0d R%0d", k, e[3:0]), e[20], e[11:4]);
        default: do_set(e[19:12]);
      endcase
    end
    chk("R3 vec base", vec_base, 5'd9);
    chk("R3 auto eoi", aeoi, 1);
    chk("R7 prio base", prio_base, 3'd2);

    // R5 special mask gating
    do_wr(0, 8'h68);
    chk("R5 smask set", smask, 1);
    do_wr(0, 8'h28);
    chk("R5 smask held", smask, 1);
    do_wr(0, 8'h48);
    chk("R5 smask clr", smask, 0);
    do_wr(0, 8'h68);

    // R2 init clears state; cascaded, no fourth word
    do_set(8'h40);
    do_wr(0, 8'h10);
    chk("R2 pulse", init_pulse, 1);
    chk("R2 isr cleared", isr, 0);
    chk("R2 state cleared", {imr, prio_base, aeoi, smask}, 0);
    @(negedge clk);
    chk("R2 pulse one cycle", init_pulse, 0);
    do_wr(1, 8'hF8);
    chk("R3 vec", vec_base, 5'd31);
    do_wr(1, 8'h55);
    chk("R3 cascade word consumed", imr, 0);
    chk("R3 cascade no mode", {aeoi, fnest}, 0);
    do_wr(1, 8'h33);
    chk("R3 mask after cascade", imr, 8'h33);

    // R3 cascaded with fourth word
    do_wr(0, 8'h11);
    do_wr(1, 8'h08);
    do_wr(1, 8'h04);
    chk("R3 mask untouched by cascade", imr, 0);
    do_wr(1, 8'h12);
    chk("R3 mode word", {fnest, aeoi}, 2'b11);
    do_wr(1, 8'h0F);
    chk("R3 mask after mode", imr, 8'h0F);
    chk("R3 vec 1", vec_base, 5'd1);

    // R3 single, no fourth word
    do_wr(0, 8'h12);
    chk("R2 modes cleared", {fnest, aeoi}, 0);
    do_wr(1, 8'h20);
    do_wr(1, 8'h77);
    chk("R3 single short path", {vec_base, imr}, {5'd4, 8'h77});

    // R8 rotate on auto eoi
    do_wr(0, 8'h80);
    chk("R8 rot on", rot, 1);
    do_wr(0, 8'h00);
    chk("R8 rot off", rot, 0);

    // R6 empty in-service: base kept
    do_wr(0, 8'hC2);
    do_wr(0, 8'hA0);
    chk("R6 empty eoi keeps base", prio_base, 3'd3);

    // R9 poll with nothing pending
    pend_vld = 1'b0;
    do_wr(0, 8'h0C);
    @(negedge clk);
    rd = 1'b1; addr = 1'b0;
    #1 chk("R9 poll none", rdata, 8'h07);
    chk("R9 no clear", irr_clr, 0);
    @(negedge clk);
    rd = 1'b0;
    #1 chk("R11 after poll", rdata, 8'h5A);

    // R9 poll hit clears request and in-service
    do_set(8'h20);
    pend_vld = 1'b1; pend_idx = 3'd5;
    do_wr(0, 8'h0C);
    @(negedge clk);
    rd = 1'b1; addr = 1'b0;
    #1 chk("R9 poll idx", rdata, 8'h05);
    chk("R9 request clear", irr_clr, 8'h20);
    @(negedge clk);
    rd = 1'b0;
    #1 chk("R9 isr cleared", isr, 0);
    chk("R9 clear ends", irr_clr, 0);

    // R10 set and clear of one bit in one cycle
    do_set(8'h01);
    @(negedge clk);
    wr = 1'b1; addr = 1'b0; wdata = 8'h60; isr_set = 8'h01;
    @(negedge clk);
    wr = 1'b0; isr_set = '0;
    chk("R10 set wins", isr, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule